// File: doc/BRIEF.md
# Linear Wrapping Burst Read Controller

This block is the clocked read front end of a 16-bit-word memory array. It comes out of reset in a plain read mode. In that mode the array word at the presented address appears on the data output one clock edge after the address is sampled. A mode input, sampled only while no burst is running, switches the block into burst mode.

In burst mode the host pulses a load strobe to capture a start address. The first word is valid after the second rising edge that follows the load. From then on, every edge on which the advance strobe is low moves to the next word. Only the five low address bits take part in the count, so the sequence stays inside the aligned block of 32 words that holds the start address and wraps back to the block's first word. Holding the advance strobe high repeats the current word, which lets the host cut the burst short or stretch it.

A word-valid flag marks the cycles that carry burst data. A registered enable stands in for the three-state control of the data pins. The data store is a small synchronous array with a plain write port, used to fill it. Deselecting the chip ends the burst. A synchronous active-high reset puts the block back in plain read mode.

Top module: `lwb_read_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `word_valid_o` and `dq_en_o` are 0, and the block is in plain read mode.
- R2: In plain read mode, `dq_o` equals the array word at the `addr_i` value sampled on the previous rising edge. `ld_n_i` and `adv_n_i` have no effect, and `word_valid_o` stays 0.
- R3: `mode_burst_i` (1 = burst, 0 = plain read) is taken in only on edges where no burst is active. A burst is active from its load edge until the edge that samples `ce_n_i` high, or until reset. A mode change requested during a burst takes effect once the burst has ended.
- R4: In burst mode, a rising edge that samples `ld_n_i` low and `ce_n_i` low captures `addr_i` as the burst start address.
- R5: The word at the start address appears on `dq_o`, with `word_valid_o` high, after the second rising edge counted from the load edge (the load edge is the first). The value of `adv_n_i` on that second edge has no effect.
- R6: After the first word, each edge that samples `adv_n_i` low moves to the next word. The word shown after k advances is at `{start[AW-1:5], (start[4:0] + k) mod 32}`.
- R7: An edge that samples `adv_n_i` high repeats the current word, and `word_valid_o` stays high.
- R8: The address bits above bit 4 never change during a burst. After offset 31 the burst continues at offset 0 of the same aligned block.
- R9: A load during a running burst restarts it at the new address. `word_valid_o` is 0 for the one cycle after that load edge, and the new first word follows with the R5 latency.
- R10: An edge that samples `ce_n_i` high ends the burst, and `word_valid_o` is 0 after that edge.
- R11: `dq_en_o` is 1 after an edge exactly when that edge sampled both `ce_n_i` and `oe_n_i` low. While it is 0, the data pins are to be treated as high impedance.
- R12: Asserting `rst` during a burst ends the burst. On the second edge with `rst` high, `dq_o` again follows `addr_i` as in R2.
- R13: An edge with `wr_en_i` high stores `wr_data_i` at `wr_addr_i`. A read issued on a later edge returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_burst_i | input | 1 | Requested mode: 1 burst, 0 plain read |
| ld_n_i | input | 1 | Load start address, active low |
| adv_n_i | input | 1 | Advance to next word, active low |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | AW | Word address |
| wr_en_i | input | 1 | Array fill write enable |
| wr_addr_i | input | AW | Array fill address |
| wr_data_i | input | DW | Array fill data |
| dq_o | output | DW | Read data |
| dq_en_o | output | 1 | Data pin drive enable (0 means high impedance) |
| word_valid_o | output | 1 | Burst word on dq_o is valid |

## Verification
The array is filled with a scrambled pattern, so every address holds a distinct word and a wrong address shows up as a wrong value. Bursts start mid-block with no wrap, at offset 30 running past 32 words, and with stalls every second or third cycle. That separates the increment, the modulo-32 wrap and the hold. A chained reload and a reset cut a burst short, which shows whether the restart latency and the return to plain read are right. A mode request made in mid-burst shows that the mode is sampled only while idle. Plain-read accesses with the strobes toggling, together with enable toggles, cover the address-following path and the drive-enable path.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_RUN  = 2'd2
  } burst_st_e;
endpackage

// File: rtl/lwb_store.sv
module lwb_store #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Single write port, registered read port: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/lwb_seq.sv
module lwb_seq
  import lwb_pkg::*;
#(
  parameter int AW        = 10,
  parameter int BURST_LEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          burst_mode_i,
  input  logic          ce_n_i,
  input  logic          ld_n_i,
  input  logic          adv_n_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          active_o,
  output logic          word_valid_o
);
  localparam int OW = $clog2(BURST_LEN);
  typedef logic [OW-1:0] off_t;

  burst_st_e     state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic          valid_d;

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    rd_addr_o = cur_q;
    valid_d   = 1'b0;
    if (!burst_mode_i) begin
      state_d   = ST_IDLE;
      rd_addr_o = addr_i;
    end else if (ce_n_i) begin
      state_d = ST_IDLE;
    end else if (!ld_n_i) begin
      state_d   = ST_LAT;
      cur_d     = addr_i;
      rd_addr_o = addr_i;
    end else begin
      unique case (state_q)
        ST_LAT: begin
          state_d = ST_RUN;
          valid_d = 1'b1;
        end
        ST_RUN: begin
          valid_d = 1'b1;
          if (!adv_n_i) begin
            cur_d = {cur_q[AW-1:OW], off_t'(cur_q[OW-1:0] + 1'b1)};
          end
          rd_addr_o = cur_d;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cur_q        <= '0;
      word_valid_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      cur_q        <= cur_d;
      word_valid_o <= valid_d;
    end
  end

  assign active_o = (state_q != ST_IDLE);

  // R8: block bits stay put while a burst runs
  p_upper_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && $past(state_q) == ST_RUN)
      |-> cur_q[AW-1:OW] == $past(cur_q[AW-1:OW]));

  // R6: an advance steps the offset by one, modulo the burst length
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && $past(state_q) == ST_RUN && !$past(adv_n_i))
      |-> cur_q[OW-1:0] == off_t'($past(cur_q[OW-1:0]) + 1'b1));

  // R7: a stall keeps the address
  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && $past(state_q) == ST_RUN && $past(adv_n_i))
      |-> $stable(cur_q));

  // R5: first valid word comes two edges after a load
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(word_valid_o) |-> $past(!ld_n_i, 2));

  // R10: no valid word after a deselected edge
  p_deselect_r10: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> $past(!ce_n_i));
endmodule

// File: rtl/lwb_oectl.sv
module lwb_oectl (
  input  logic clk,
  input  logic rst,
  input  logic ce_n_i,
  input  logic oe_n_i,
  output logic en_o
);
  always_ff @(posedge clk) begin
    if (rst) en_o <= 1'b0;
    else     en_o <= !ce_n_i && !oe_n_i;
  end

  // R11: drive enable only after a fully enabled edge
  p_en_follows_r11: assert property (@(posedge clk) disable iff (rst)
    en_o |-> $past(!ce_n_i && !oe_n_i));

  p_en_drop_r11: assert property (@(posedge clk) disable iff (rst)
    $past(ce_n_i || oe_n_i) |-> !en_o);
endmodule

// File: rtl/lwb_read_ctrl.sv
module lwb_read_ctrl #(
  parameter int AW        = 10,
  parameter int DW        = 16,
  parameter int BURST_LEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_burst_i,
  input  logic          ld_n_i,
  input  logic          adv_n_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_en_o,
  output logic          word_valid_o
);
  logic          mode_q;
  logic          active;
  logic [AW-1:0] rd_addr;

  // Mode register: only sampled when no burst is in progress (R3)
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 1'b0;
    else if (!active) mode_q <= mode_burst_i;
  end

  lwb_seq #(.AW(AW), .BURST_LEN(BURST_LEN)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .burst_mode_i (mode_q),
    .ce_n_i       (ce_n_i),
    .ld_n_i       (ld_n_i),
    .adv_n_i      (adv_n_i),
    .addr_i       (addr_i),
    .rd_addr_o    (rd_addr),
    .active_o     (active),
    .word_valid_o (word_valid_o)
  );

  lwb_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .we_i    (wr_en_i),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (rd_addr),
    .rdata_o (dq_o)
  );

  lwb_oectl u_oectl (
    .clk    (clk),
    .rst    (rst),
    .ce_n_i (ce_n_i),
    .oe_n_i (oe_n_i),
    .en_o   (dq_en_o)
  );

  // R3: the mode only moves on an idle edge
  p_mode_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> !$past(active));

  // R2: plain read mode never flags burst words
  p_plain_novalid_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_q) |-> !word_valid_o);
endmodule

// File: tb/lwb_read_ctrl_tb_top.sv
module lwb_read_ctrl_tb_top;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int BL = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, mode_burst_i, ld_n_i, adv_n_i, ce_n_i, oe_n_i, wr_en_i;
  logic [AW-1:0] addr_i, wr_addr_i;
  logic [DW-1:0] wr_data_i, dq_o;
  logic          dq_en_o, word_valid_o;

  lwb_read_ctrl #(.AW(AW), .DW(DW), .BURST_LEN(BL)) dut_i (
    .clk(clk), .rst(rst), .mode_burst_i(mode_burst_i), .ld_n_i(ld_n_i),
    .adv_n_i(adv_n_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .dq_o(dq_o), .dq_en_o(dq_en_o), .word_valid_o(word_valid_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 40503) ^ 23130);
  endfunction

  function automatic logic [AW-1:0] baddr(logic [AW-1:0] a, int off);
    return {a[AW-1:5], 5'((int'(a[4:0]) + off) % BL)};
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected word per valid cycle
  always @(negedge clk) begin
    if (!done && word_valid_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected valid word", dq_o, '0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dq_o == e, t, dq_o, e);
      end
    end
  end

  task automatic push(logic [DW-1:0] w, string t);
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  // Driver: one burst, optional stalls, optional end by deselect
  task automatic burst(logic [AW-1:0] a, int n, int stall_every, bit finish);
    int off = 0;
    @(negedge clk);
    ld_n_i = 1'b0; addr_i = a; adv_n_i = 1'b0;
    @(negedge clk);
    // R9: valid is low right after any load edge
    check(word_valid_o == 1'b0, "R9 latency cycle valid", DW'(word_valid_o), '0);
    ld_n_i = 1'b1; adv_n_i = 1'b0;        // advance ignored on 2nd edge (R5)
    addr_i = ~a;                           // captured address must be kept (R4)
    push(pat(int'(a)), "R4 R5 first word");
    for (int k = 1; k < n; k++) begin
      bit stall;
      @(negedge clk);
      stall   = (stall_every != 0) && (k % stall_every == 0);
      adv_n_i = stall;
      if (!stall) off++;
      push(pat(int'(baddr(a, off))),
           stall ? "R7 stall word" : ((int'(a[4:0]) + off >= BL) ? "R8 wrapped word" : "R6 next word"));
    end
    if (finish) begin
      @(negedge clk);
      ce_n_i = 1'b1; adv_n_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(word_valid_o == 1'b0, "R10 valid after deselect", DW'(word_valid_o), '0);
      ce_n_i = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 60000);
    check(0, "watchdog expired", '0, '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_burst_i = 1'b0; ld_n_i = 1'b1; adv_n_i = 1'b1;
    ce_n_i = 1'b1; oe_n_i = 1'b1; addr_i = '0;
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    check(word_valid_o == 1'b0, "R1 reset valid", DW'(word_valid_o), '0);
    check(dq_en_o == 1'b0, "R1 reset enable", DW'(dq_en_o), '0);
    rst = 1'b0;
    @(negedge clk);
    check(word_valid_o == 1'b0 && dq_en_o == 1'b0, "R1 after reset", DW'({dq_en_o, word_valid_o}), '0);

    // Fill the array (R13)
    for (int i = 0; i < (1 << AW); i++) begin
      wr_en_i = 1'b1; wr_addr_i = AW'(i); wr_data_i = pat(i);
      @(negedge clk);
    end
    wr_en_i = 1'b0;

    // Drive enable (R11)
    ce_n_i = 1'b0; oe_n_i = 1'b0;
    @(negedge clk);
    check(dq_en_o == 1'b1, "R11 enable on", DW'(dq_en_o), 1);
    oe_n_i = 1'b1;
    @(negedge clk);
    check(dq_en_o == 1'b0, "R11 oe off", DW'(dq_en_o), 0);
    oe_n_i = 1'b0; ce_n_i = 1'b1;
    @(negedge clk);
    check(dq_en_o == 1'b0, "R11 ce off", DW'(dq_en_o), 0);
    ce_n_i = 1'b0;

    // Plain read mode, strobes toggling (R2)
    addr_i = 10'd5; ld_n_i = 1'b0; adv_n_i = 1'b0;
    @(negedge clk);
    check(dq_o == pat(5), "R2 plain read", dq_o, pat(5));
    check(word_valid_o == 1'b0, "R2 no valid in plain mode", DW'(word_valid_o), '0);
    addr_i = 10'd700; ld_n_i = 1'b1;
    @(negedge clk);
    check(dq_o == pat(700), "R2 plain read follows", dq_o, pat(700));

    // Write then read back (R13)
    wr_en_i = 1'b1; wr_addr_i = 10'd3; wr_data_i = ~pat(3);
    @(negedge clk);
    wr_en_i = 1'b0; addr_i = 10'd3;
    @(negedge clk);
    @(negedge clk);
    check(dq_o == ~pat(3), "R13 written word", dq_o, ~pat(3));
    wr_en_i = 1'b1; wr_data_i = pat(3);
    @(negedge clk);
    wr_en_i = 1'b0;

    // Burst mode
    mode_burst_i = 1'b1;
    @(negedge clk);
    burst(10'h005, 10, 0, 1);
    burst(10'h1FE, 40, 0, 1);
    burst(10'h2E0, 70, 3, 1);
    burst(10'h0C7, 12, 0, 0);
    mode_burst_i = 1'b0;              // request during burst: must wait (R3)
    burst(10'h33A, 20, 2, 1);         // mid-burst reload (R9)
    repeat (3) @(negedge clk);
    addr_i = 10'd9;
    @(negedge clk);
    check(dq_o == pat(9), "R3 mode taken after burst", dq_o, pat(9));
    check(word_valid_o == 1'b0, "R3 plain mode no valid", DW'(word_valid_o), '0);

    // Reset in mid-burst (R12)
    mode_burst_i = 1'b1;
    repeat (2) @(negedge clk);
    burst(10'h240, 6, 0, 0);
    @(negedge clk);
    rst = 1'b1; addr_i = 10'd44;
    @(negedge clk);
    check(word_valid_o == 1'b0, "R12 valid cleared", DW'(word_valid_o), '0);
    @(negedge clk);
    check(dq_o == pat(44), "R12 back to plain read", dq_o, pat(44));
    mode_burst_i = 1'b0; rst = 1'b0;
    @(negedge clk);

    check(exp_q.size() == 0, "R6 all expected words seen", DW'(exp_q.size()), '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule